// File: doc/BRIEF.md
# SPI Command Decoder with Parity-Checked Register Bank

This block is an SPI slave. A host controller sends it fixed 16-bit command frames. Each frame holds either a single action or a read or write of one register in a small bank. The action commands set the block's control levels: the modulation clamp, sleep and AGC hold. A further action requests a soft reset, which appears as a one-cycle pulse. The bank holds six configuration bytes and one column-parity byte, and each of these bytes is stored with its own row-parity bit. A status byte can be read but not written. The block checks row and column parity all the time and reports any mismatch.

The serial pins are SCLK, CS (active low), SDI and SDO, and they are used in SPI mode 0. All three inputs pass through synchronizers into the system clock, and the block finds the SCLK edges there. A frame state machine handles each chip-select window. **FR_IDLE** waits for CS to go low, then moves to **FR_ACTIVE** (transition *window open*). **FR_ACTIVE** shifts in one SDI bit on each SCLK rising edge. When CS rises, the machine takes one of two transitions:

- *commit*: the window held a non-zero multiple of 16 edges, so the machine goes to **FR_EXEC**.
- *abort*: any other edge count sends it straight back to **FR_IDLE**.

**FR_EXEC** lasts one cycle, in which the last complete frame is executed. From there the machine goes back to **FR_IDLE** (*done*), or to **FR_ACTIVE** if CS is already low again (*back-to-back*).

Read data is shifted out on SDO, changing on SCLK falling edges, during the chip-select window that follows the read.

Top module: `spi_cmd_decoder`

## Requirements
- R1: A frame is 16 bits, sent MSB first: opcode[15:13], address[12:9], data[8:1], row parity[0]. The frame is executed one system cycle after the synchronized CS rises.
- R2: A window whose SCLK rising-edge count is zero, or is not a multiple of 16, is discarded and has no effect.
- R3: Opcode 000 sets clamp_en to 1 and opcode 001 clears it to 0.
- R4: Opcode 010 sets sleep. Any other executed opcode clears sleep, and a repeated 010 keeps sleep at 1.
- R5: Opcode 011 sets agc_hold and opcode 100 clears it.
- R6: Opcode 101 drives soft_rst_pulse high for exactly one cycle. It clears clamp_en, sleep and agc_hold, and it returns the bank to its reset contents.
- R7: Opcode 111 writes the data byte and the received parity bit to addresses 0 to 6, where 0 to 5 are the configuration bytes and 6 is the column-parity byte. Opcode 110 reads back exactly the stored pair.
- R8: After a committed read, the next window shifts out the data byte MSB first on SDO, then its parity bit, then seven zeros. When no read is pending, SDO is 0.
- R9: Writes to address 7 and to addresses 8 to 15 change nothing. Addresses 8 to 15 read back as all zeros, parity bit included.
- R10: Address 7 reads the status byte, with parity_err in bit 0, sleep in bit 1, clamp_en in bit 2, agc_hold in bit 3 and zeros above. The status byte is sent with its odd parity bit and reflects the state before the read takes effect.
- R11: parity_err is 1 in either of two cases. A stored byte and its row bit hold an even number of ones, or some bit position across configuration bytes 0 to 5 and the column byte holds an even number of ones.
- R12: After reset, all control outputs and SDO are 0. The configuration bytes are 0x00, the column byte is 0xFF, every row bit is 1, and parity_err is 0.
- R13: In a window of 32 or more edges that is a multiple of 16, only the last complete frame is executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk | input | 1 | Serial clock from host, idles low |
| cs_n | input | 1 | Chip select, active low |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial read data to host |
| clamp_en | output | 1 | Modulation clamp enable level |
| sleep | output | 1 | Sleep level |
| agc_hold | output | 1 | AGC hold level |
| soft_rst_pulse | output | 1 | One-cycle soft reset request |
| parity_err | output | 1 | Row or column parity mismatch |

## Verification
The checker watches the control levels on every cycle. Each change of clamp_en, each rise of sleep or agc_hold, and each soft-reset pulse must follow an executed frame. The soft-reset pulse must last one cycle, and it must leave all levels cleared. Only the bench's scenarios can show the serial side: decoding of each opcode, discarding of windows with 0, 15 or 17 edges, last-frame-wins in a 32-edge window, and the bit order of read data. The same holds for the parity flag as row and column faults are written in and repaired, and for the status byte and unused addresses reading as specified.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam int FRAME_BITS = 16;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 4;

    typedef enum logic [2:0] {
        OP_CLAMP_ON  = 3'b000,
        OP_CLAMP_OFF = 3'b001,
        OP_SLEEP     = 3'b010,
        OP_AGC_HOLD  = 3'b011,
        OP_AGC_FREE  = 3'b100,
        OP_SOFT_RST  = 3'b101,
        OP_READ      = 3'b110,
        OP_WRITE     = 3'b111
    } opcode_e;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_ACTIVE,
        FR_EXEC
    } frame_state_e;

    typedef struct packed {
        opcode_e            op;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  data;
        logic               par;
    } frame_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import spi_cmd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cs_lo,
    input  logic   sclk_rise,
    input  logic   sdi_s,
    output logic   cmd_vld,
    output logic   win_end,
    output frame_t cmd
);
    localparam int CNT_W = $clog2(FRAME_BITS);

    frame_state_e            st, st_nx;
    logic [CNT_W-1:0]        bit_cnt;
    logic                    got_frame;
    logic [FRAME_BITS-2:0]   sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= FR_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            FR_IDLE:   if (cs_lo) st_nx = FR_ACTIVE;
            FR_ACTIVE: if (!cs_lo)
                           st_nx = (bit_cnt == '0 && got_frame) ? FR_EXEC : FR_IDLE;
            FR_EXEC:   st_nx = cs_lo ? FR_ACTIVE : FR_IDLE;
            default:   st_nx = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            got_frame <= 1'b0;
            sh        <= '0;
            cmd       <= '0;
        end else if (st != FR_ACTIVE) begin
            bit_cnt   <= '0;
            got_frame <= 1'b0;
        end else if (sclk_rise) begin
            sh      <= {sh[FRAME_BITS-3:0], sdi_s};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CNT_W'(FRAME_BITS - 1)) begin
                got_frame <= 1'b1;
                cmd       <= frame_t'({sh, sdi_s});
            end
        end
    end

    always_comb begin
        cmd_vld = (st == FR_EXEC);
        win_end = (st == FR_ACTIVE) && !cs_lo;
    end
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_cmd_pkg::*;
#(
    parameter int NUM_CFG = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_par,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] status,
    output logic [DATA_W:0]   rd_word,
    output logic              par_err
);
    localparam int NUM_ROWS = NUM_CFG + 1;
    localparam int COL_IDX  = NUM_CFG;
    localparam int IDX_W    = $clog2(NUM_ROWS);

    logic [DATA_W-1:0]   data [NUM_ROWS];
    logic [NUM_ROWS-1:0] par;
    logic [NUM_ROWS-1:0] row_bad;
    logic [DATA_W-1:0]   col_bad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_ROWS; r++) data[r] <= (r == COL_IDX) ? '1 : '0;
            par <= '1;
        end else if (clr) begin
            for (int r = 0; r < NUM_ROWS; r++) data[r] <= (r == COL_IDX) ? '1 : '0;
            par <= '1;
        end else if (wr_en && wr_addr < ADDR_W'(NUM_ROWS)) begin
            data[wr_addr[IDX_W-1:0]] <= wr_data;
            par[wr_addr[IDX_W-1:0]]  <= wr_par;
        end
    end

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        assign row_bad[r] = ~^{data[r], par[r]};
    end

    for (genvar b = 0; b < DATA_W; b++) begin : g_col
        logic [NUM_ROWS-1:0] slice;
        for (genvar r = 0; r < NUM_ROWS; r++) begin : g_bit
            assign slice[r] = data[r][b];
        end
        assign col_bad[b] = ~^slice;
    end

    assign par_err = (|row_bad) | (|col_bad);

    always_comb begin
        rd_word = '0;
        if (rd_addr < ADDR_W'(NUM_ROWS))
            rd_word = {data[rd_addr[IDX_W-1:0]], par[rd_addr[IDX_W-1:0]]};
        else if (rd_addr == ADDR_W'(NUM_ROWS))
            rd_word = {status, ~^status};
    end
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
    import spi_cmd_pkg::*;
#(
    parameter int NUM_CFG     = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    output logic sdo,
    output logic clamp_en,
    output logic sleep,
    output logic agc_hold,
    output logic soft_rst_pulse,
    output logic parity_err
);
    localparam int PAD_W = FRAME_BITS - DATA_W - 1;

    logic [2:0]        sync_q;
    logic              sclk_s, csn_s, sdi_s, sclk_d;
    logic              sclk_rise, sclk_fall, cs_lo;
    logic              cmd_vld, win_end;
    frame_t            cmd;
    logic [DATA_W:0]   rd_word;
    logic [DATA_W-1:0] status;
    logic [FRAME_BITS-1:0] tx;

    spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({sclk, cs_n, sdi}), .q(sync_q)
    );
    assign {sclk_s, csn_s, sdi_s} = sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign cs_lo     = ~csn_s;

    spi_frame_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_lo(cs_lo), .sclk_rise(sclk_rise),
        .sdi_s(sdi_s), .cmd_vld(cmd_vld), .win_end(win_end), .cmd(cmd)
    );

    assign status = {{(DATA_W-4){1'b0}}, agc_hold, clamp_en, sleep, parity_err};

    spi_reg_bank #(.NUM_CFG(NUM_CFG)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .clr(cmd_vld && cmd.op == OP_SOFT_RST),
        .wr_en(cmd_vld && cmd.op == OP_WRITE),
        .wr_addr(cmd.addr), .wr_data(cmd.data), .wr_par(cmd.par),
        .rd_addr(cmd.addr), .status(status),
        .rd_word(rd_word), .par_err(parity_err)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clamp_en       <= 1'b0;
            sleep          <= 1'b0;
            agc_hold       <= 1'b0;
            soft_rst_pulse <= 1'b0;
        end else begin
            soft_rst_pulse <= 1'b0;
            if (cmd_vld) begin
                if (cmd.op != OP_SLEEP) sleep <= 1'b0;
                unique case (cmd.op)
                    OP_CLAMP_ON:  clamp_en <= 1'b1;
                    OP_CLAMP_OFF: clamp_en <= 1'b0;
                    OP_SLEEP:     sleep    <= 1'b1;
                    OP_AGC_HOLD:  agc_hold <= 1'b1;
                    OP_AGC_FREE:  agc_hold <= 1'b0;
                    OP_SOFT_RST: begin
                        soft_rst_pulse <= 1'b1;
                        clamp_en       <= 1'b0;
                        agc_hold       <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tx <= '0;
        else if (cmd_vld && cmd.op == OP_READ)
            tx <= {rd_word, {PAD_W{1'b0}}};
        else if (win_end)
            tx <= '0;
        else if (sclk_fall && cs_lo)
            tx <= {tx[FRAME_BITS-2:0], 1'b0};
    end

    assign sdo = tx[FRAME_BITS-1] & cs_lo;
endmodule

// File: rtl/spi_cmd_checker.sv
module spi_cmd_checker (
    input logic clk,
    input logic rst_n,
    input logic cmd_vld,
    input logic clamp_en,
    input logic sleep,
    input logic agc_hold,
    input logic soft_rst_pulse
);
    // R6
    soft_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_pulse |=> !soft_rst_pulse);

    // R6
    soft_clears_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_pulse |-> (!clamp_en && !sleep && !agc_hold));

    // R6
    soft_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_pulse |-> $past(cmd_vld));

    // R3
    clamp_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clamp_en) |-> $past(cmd_vld));

    // R4
    sleep_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep) |-> $past(cmd_vld));

    // R5
    agc_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(agc_hold) |-> $past(cmd_vld));
endmodule

bind spi_cmd_decoder spi_cmd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .clamp_en(clamp_en),
    .sleep(sleep), .agc_hold(agc_hold), .soft_rst_pulse(soft_rst_pulse)
);

// File: tb/sim_spi_cmd_decoder.sv
module sim_spi_cmd_decoder;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic sdi = 1'b0;
    logic sdo, clamp_en, sleep, agc_hold, soft_rst_pulse, parity_err;

    int checks = 0, errors = 0;
    int mon_checks = 0, mon_errors = 0;
    int pulse_cnt = 0;
    bit done = 1'b0;
    bit cmp_pending = 1'b0;

    logic [15:0] exp_q [$];
    string       tag_q [$];
    logic [15:0] rx_q  [$];

    always #5 clk = ~clk;

    spi_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
        .clamp_en(clamp_en), .sleep(sleep), .agc_hold(agc_hold),
        .soft_rst_pulse(soft_rst_pulse), .parity_err(parity_err)
    );

    function automatic logic [15:0] mk(input logic [2:0] op, input logic [3:0] a,
                                       input logic [7:0] d, input logic p);
        return {op, a, d, p};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [31:0] w, input int n, output logic [31:0] rx);
        rx = '0;
        @(negedge clk) cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = w[i];
            repeat (H) @(negedge clk);
            sclk = 1'b1;
            rx = {rx[30:0], sdo};
            repeat (H) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        sdi  = 1'b0;
        repeat (12) @(negedge clk);
        if (cmp_pending && n == 16) rx_q.push_back(rx[15:0]);
        cmp_pending = 1'b0;
    endtask

    task automatic send(input logic [15:0] f);
        logic [31:0] rx;
        xfer({16'h0, f}, 16, rx);
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
        send(mk(3'b110, a, 8'h00, 1'b0));
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        cmp_pending = 1'b1;
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            if (rx_q.size() > 0) begin
                logic [15:0] got, want;
                string t;
                got  = rx_q.pop_front();
                want = exp_q.pop_front();
                t    = tag_q.pop_front();
                mon_checks++;
                if (got !== want) begin
                    mon_errors++;
                    $display("FAIL %s: actual=%h expected=%h", t, got, want);
                end
            end
        end
    end

    initial begin : pulse_counter
        forever begin
            @(posedge clk);
            if (soft_rst_pulse === 1'b1) pulse_cnt++;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog: actual=timeout expected=finished");
            $display("Result: errors=%0d of %0d checks", errors + mon_errors, checks + mon_checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rx;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        chk("R12 reset levels", {clamp_en, sleep, agc_hold, soft_rst_pulse}, 0);
        chk("R12 reset parity_err", parity_err, 0);
        chk("R12 reset sdo", sdo, 0);

        rd(4'd0, 16'h0080, "R12 R1 cfg0 reset read");
        rd(4'd6, 16'hFF80, "R12 column byte reset read");

        send(mk(3'b000, 4'd0, 8'h00, 1'b0));
        chk("R3 clamp on", clamp_en, 1);
        xfer({16'h0, mk(3'b001, 4'd0, 8'h00, 1'b0)}, 16, rx);
        chk("R8 sdo zero with no read pending", rx, 0);
        chk("R3 clamp off", clamp_en, 0);

        send(mk(3'b111, 4'd2, 8'hA5, 1'b1));
        chk("R11 column mismatch flagged", parity_err, 1);
        send(mk(3'b111, 4'd6, 8'h5A, 1'b1));
        chk("R11 column repaired", parity_err, 0);
        rd(4'd2, 16'hA580, "R7 R8 cfg2 readback");
        rd(4'd6, 16'h5A80, "R7 column readback");

        send(mk(3'b111, 4'd1, 8'h00, 1'b0));
        chk("R11 row mismatch flagged", parity_err, 1);
        rd(4'd1, 16'h0000, "R7 stored bad parity readback");
        send(mk(3'b111, 4'd1, 8'h00, 1'b1));
        chk("R11 row repaired", parity_err, 0);

        send(mk(3'b111, 4'd7, 8'hFF, 1'b0));
        send(mk(3'b111, 4'd9, 8'h33, 1'b1));
        chk("R9 ignored writes keep parity", parity_err, 0);
        rd(4'd9, 16'h0000, "R9 unused address reads zero");
        rd(4'd1, 16'h0080, "R9 no alias into cfg1");

        send(mk(3'b000, 4'd0, 8'h00, 1'b0));
        send(mk(3'b011, 4'd0, 8'h00, 1'b0));
        chk("R5 agc hold on", agc_hold, 1);
        rd(4'd7, 16'h0C80, "R10 status read");

        send(mk(3'b010, 4'd0, 8'h00, 1'b0));
        chk("R4 sleep entered", sleep, 1);
        send(mk(3'b010, 4'd5, 8'h77, 1'b1));
        chk("R4 repeated sleep stays", sleep, 1);
        send(mk(3'b100, 4'd0, 8'h00, 1'b0));
        chk("R4 other command wakes", sleep, 0);
        chk("R5 agc hold off", agc_hold, 0);

        xfer({17'h0, mk(3'b001, 4'd0, 8'h00, 1'b0) >> 1}, 15, rx);
        chk("R2 15-edge window discarded", clamp_en, 1);
        xfer({15'h0, mk(3'b001, 4'd0, 8'h00, 1'b0), 1'b0}, 17, rx);
        chk("R2 17-edge window discarded", clamp_en, 1);
        send(mk(3'b010, 4'd0, 8'h00, 1'b0));
        xfer(32'h0, 0, rx);
        chk("R2 empty window discarded", sleep, 1);
        xfer({mk(3'b001, 4'd0, 8'h00, 1'b0), mk(3'b011, 4'd0, 8'h00, 1'b0)}, 32, rx);
        chk("R13 last frame wins clamp", clamp_en, 1);
        chk("R13 last frame wins agc", agc_hold, 1);
        chk("R13 last frame wakes", sleep, 0);

        send(mk(3'b111, 4'd0, 8'h81, 1'b1));
        chk("R11 column mismatch before reset", parity_err, 1);
        pulse_cnt = 0;
        send(mk(3'b101, 4'd0, 8'h00, 1'b0));
        chk("R6 one pulse", pulse_cnt, 1);
        chk("R6 levels cleared", {clamp_en, sleep, agc_hold}, 0);
        chk("R6 parity clean", parity_err, 0);
        rd(4'd0, 16'h0080, "R6 cfg0 restored");
        rd(4'd15, 16'h0000, "R9 top address reads zero");
        send(mk(3'b001, 4'd0, 8'h00, 1'b0));

        while (rx_q.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R8 all reads compared", exp_q.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors + mon_errors, checks + mon_checks);
        $finish;
    end
endmodule